// File: doc/BRIEF.md
# Single-Access SDRAM Controller

This block drives a single-data-rate, 16-bit-wide SDRAM with four banks from a plain user request port. After reset it holds the memory idle for a programmable power-up delay. It then precharges every bank, issues a configurable number of auto-refresh cycles and programs the mode register for CAS latency 3 with a burst of two. Only after that does it accept requests.

Each accepted request is served on its own. The controller opens the row with ACTIVE. It then issues READ or WRITE with auto-precharge, moves two 16-bit words and waits out the precharge recovery before it takes anything else. An internal interval timer raises a refresh request. A pending refresh is served ahead of any new user request as soon as the controller is idle.

The request side is valid/ready. A request is taken on a clock edge where `req_valid` and `req_ready` are both high. The requester must hold its address, direction and write data stable while `req_valid` is high and `req_ready` is low. `req_ready` stays low during initialization, through every access and its recovery, and while a refresh is pending or running. The read response is a one-cycle `rd_valid` pulse that cannot be stalled. A requester that issues reads must be able to take the result in the cycle it appears.

Top module: `sdram_single_ctrl`

## Requirements
- R1: Commands appear on {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} with these encodings: NOP 0111, ACTIVE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, REFRESH 0001, MODE 0000. After reset only NOP is driven for INIT_WAIT cycles. PRECHARGE with sd_addr[10]=1 then appears exactly INIT_WAIT cycles after reset is released.
- R2: PRECHARGE is followed T_RP cycles later by the first of INIT_REFS REFRESH commands, spaced T_RFC apart. T_RFC after the last of them comes MODE with sd_addr = 12'h031 (burst-length field A[2:0]=1, CAS field A[6:4]=3, all other bits 0). `init_done` and `req_ready` first rise T_MRD cycles after MODE and never before it.
- R3: A request address is split as bank = addr[21:20], row = addr[19:8], column = addr[7:0]. ACTIVE carries bank on sd_ba and row on sd_addr. READ/WRITE carries the same bank, the column on sd_addr[7:0], sd_addr[10]=1 (auto-precharge) and zeros elsewhere.
- R4: READ or WRITE is issued exactly T_RCD cycles after its ACTIVE.
- R5: sd_dq_oe is high only in the WRITE command cycle and the cycle after it. In those cycles sd_dq_out carries wdata[15:0] and then wdata[31:16]. sd_dqm is always 00.
- R6: The controller samples sd_dq_in 4 and 5 cycles after the READ cycle, that is CAS latency 3 counted from the memory's command edge. rd_valid pulses one cycle, CAS_LAT+2 cycles after the READ cycle, with rd_data = {second word, first word}. The memory returns the second word from column col^1, so reading column c-1 after a write at odd column c gives the two halves swapped.
- R7: After a request is taken, req_ready stays low until the access and its recovery are complete. Exactly one ACTIVE is issued per accepted request.
- R8: REFRESH is issued at most REF_INTERVAL plus one access duration after the previous one, or after initialization for the first. While a refresh is pending, req_ready is low.
- R9: After any REFRESH in normal operation, no other command is issued for T_RFC cycles.
- R10: Data written at an address reads back unchanged at that address for every bank and for the extreme rows and columns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} word address |
| req_wdata | input | 32 | Write data, low half is the first burst word |
| rd_valid | output | 1 | One-cycle read result strobe |
| rd_data | output | 32 | Read result, first word in the low half |
| init_done | output | 1 | Power-up sequence finished |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column/mode address |
| sd_dqm | output | 2 | Byte masks, held low |
| sd_dq_out | output | 16 | Data toward memory |
| sd_dq_oe | output | 1 | Drive enable for sd_dq_out |
| sd_dq_in | input | 16 | Data from memory |

## Verification
A wrong state in the power-up sequencer shows up at once on the command pins as a command that is early, late or missing. A wrong counter in the access engine moves READ or WRITE away from the T_RCD slot of its ACTIVE, or moves the data enable off its two cycles. Either fault is visible within one access. A read-pipeline fault is caught by rd_valid arriving off its CAS_LAT+2 slot or by corrupted data. A stuck refresh request shows as a refresh gap longer than one interval plus one access, or as req_ready never returning.

// File: rtl/sdc_pkg.sv
package sdc_pkg;
  localparam int BANK_W  = 2;
  localparam int ROW_W   = 12;
  localparam int COL_W   = 8;
  localparam int ADDR_W  = BANK_W + ROW_W + COL_W;
  localparam int WORD_W  = 16;
  localparam int CAS_LAT = 3;
  // mode word: burst of two, sequential order, CAS latency 3
  localparam logic [ROW_W-1:0] MODE_WORD = 12'h031;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_REF  = 4'b0001,
    CMD_PRE  = 4'b0010,
    CMD_ACT  = 4'b0011,
    CMD_WR   = 4'b0100,
    CMD_RD   = 4'b0101,
    CMD_NOP  = 4'b0111
  } sd_cmd_e;
endpackage

// File: rtl/sdc_init_seq.sv
module sdc_init_seq import sdc_pkg::*; #(
  parameter int INIT_WAIT = 13334,
  parameter int T_RP      = 3,
  parameter int T_RFC     = 9,
  parameter int T_MRD     = 2,
  parameter int INIT_REFS = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  output sd_cmd_e          cmd,
  output logic [ROW_W-1:0] addr,
  output logic             done
);
  localparam int CW = $clog2(INIT_WAIT + T_RP + T_RFC + T_MRD + 2);
  localparam int RW = $clog2(INIT_REFS + 1);

  typedef enum logic [2:0] {S_WAIT, S_REF, S_MODE, S_FIN, S_DONE} ist_e;
  ist_e          st;
  logic [CW-1:0] cnt;
  logic [RW-1:0] refs;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_WAIT;
      cnt  <= CW'(INIT_WAIT - 1);
      refs <= '0;
      cmd  <= CMD_NOP;
      addr <= '0;
      done <= 1'b0;
    end else begin
      cmd  <= CMD_NOP;
      addr <= '0;
      if (st != S_DONE) begin
        if (cnt != '0) begin
          cnt <= cnt - 1'b1;
        end else begin
          case (st)
            S_WAIT: begin
              cmd      <= CMD_PRE;
              addr[10] <= 1'b1;
              cnt      <= CW'(T_RP - 1);
              st       <= S_REF;
            end
            S_REF: begin
              cmd  <= CMD_REF;
              cnt  <= CW'(T_RFC - 1);
              refs <= refs + 1'b1;
              if (refs == RW'(INIT_REFS - 1)) st <= S_MODE;
            end
            S_MODE: begin
              cmd  <= CMD_MODE;
              addr <= MODE_WORD;
              cnt  <= CW'(T_MRD - 1);
              st   <= S_FIN;
            end
            default: begin
              st   <= S_DONE;
              done <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  AST_DONE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R2
endmodule

// File: rtl/sdc_refresh_tmr.sv
module sdc_refresh_tmr #(
  parameter int REF_INTERVAL = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic ack,
  output logic pending
);
  localparam int CW = $clog2(REF_INTERVAL + 1);
  logic [CW-1:0] cnt;
  logic          hit;

  assign hit = en && (cnt == CW'(REF_INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt     <= '0;
      pending <= 1'b0;
    end else begin
      if (!en || hit) cnt <= '0;
      else            cnt <= cnt + 1'b1;
      if (hit)        pending <= 1'b1;
      else if (ack)   pending <= 1'b0;
    end
  end

  AST_PENDING_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pending && !ack) |=> pending); // R8
endmodule

// File: rtl/sdc_access_fsm.sv
module sdc_access_fsm import sdc_pkg::*; #(
  parameter int T_RCD = 3,
  parameter int T_RFC = 9,
  parameter int T_RP  = 3,
  parameter int T_WR  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_done,
  input  logic              ref_pending,
  output logic              ref_ack,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [2*WORD_W-1:0] req_wdata,
  output logic              rd_valid,
  output logic [2*WORD_W-1:0] rd_data,
  output sd_cmd_e           cmd,
  output logic [BANK_W-1:0] ba,
  output logic [ROW_W-1:0]  addr,
  output logic [WORD_W-1:0] dq_out,
  output logic              dq_oe,
  input  logic [WORD_W-1:0] dq_in
);
  localparam int MAXC = T_RFC + T_RCD + T_WR + T_RP + CAS_LAT + 1;
  localparam int CW   = $clog2(MAXC + 1);
  localparam int PD   = CAS_LAT + 2;

  typedef enum logic [1:0] {M_IDLE, M_RCD, M_WR2, M_WAIT} mst_e;
  mst_e                 st;
  logic [CW-1:0]        cnt;
  logic                 wr_q;
  logic [COL_W-1:0]     col_q;
  logic [2*WORD_W-1:0]  wdata_q;
  logic [PD-1:0]        rd_pipe;
  logic [WORD_W-1:0]    lo_q;
  logic                 issue_rd;

  assign req_ready = init_done && (st == M_IDLE) && !ref_pending;
  assign ref_ack   = init_done && (st == M_IDLE) && ref_pending;
  assign issue_rd  = (st == M_RCD) && (cnt == '0) && !wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= M_IDLE; cnt <= '0; wr_q <= 1'b0; col_q <= '0; wdata_q <= '0;
      cmd <= CMD_NOP; ba <= '0; addr <= '0; dq_out <= '0; dq_oe <= 1'b0;
    end else begin
      cmd   <= CMD_NOP;
      dq_oe <= 1'b0;
      case (st)
        M_IDLE: begin
          if (ref_ack) begin
            cmd <= CMD_REF;
            cnt <= CW'(T_RFC - 1);
            st  <= M_WAIT;
          end else if (req_valid && req_ready) begin
            wr_q    <= req_write;
            col_q   <= req_addr[COL_W-1:0];
            wdata_q <= req_wdata;
            cmd     <= CMD_ACT;
            ba      <= req_addr[ADDR_W-1 -: BANK_W];
            addr    <= req_addr[COL_W +: ROW_W];
            cnt     <= CW'(T_RCD - 1);
            st      <= M_RCD;
          end
        end
        M_RCD: begin
          if (cnt != '0) begin
            cnt <= cnt - 1'b1;
          end else begin
            addr <= '0;
            addr[COL_W-1:0] <= col_q;
            addr[10] <= 1'b1;
            if (wr_q) begin
              cmd    <= CMD_WR;
              dq_out <= wdata_q[WORD_W-1:0];
              dq_oe  <= 1'b1;
              st     <= M_WR2;
            end else begin
              cmd <= CMD_RD;
              cnt <= CW'(CAS_LAT + T_RP);
              st  <= M_WAIT;
            end
          end
        end
        M_WR2: begin
          dq_out <= wdata_q[2*WORD_W-1:WORD_W];
          dq_oe  <= 1'b1;
          cnt    <= CW'(T_WR + T_RP - 1);
          st     <= M_WAIT;
        end
        default: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else           st  <= M_IDLE;
        end
      endcase
    end
  end

  // read return pipeline: word 1 at stage CAS_LAT, word 2 one stage later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_pipe <= '0; lo_q <= '0; rd_valid <= 1'b0; rd_data <= '0;
    end else begin
      rd_pipe  <= {rd_pipe[PD-2:0], issue_rd};
      rd_valid <= rd_pipe[CAS_LAT+1];
      if (rd_pipe[CAS_LAT])   lo_q    <= dq_in;
      if (rd_pipe[CAS_LAT+1]) rd_data <= {dq_in, lo_q};
    end
  end

  AST_RCD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> $past(cmd, T_RCD) == CMD_ACT); // R4
  AST_OE_BURST: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == CMD_WR || $past(cmd) == CMD_WR)); // R5
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R7
endmodule

// File: rtl/sdram_single_ctrl.sv
module sdram_single_ctrl import sdc_pkg::*; #(
  parameter int INIT_WAIT    = 13334,
  parameter int INIT_REFS    = 2,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 9,
  parameter int T_MRD        = 2,
  parameter int T_RCD        = 3,
  parameter int T_WR         = 2,
  parameter int REF_INTERVAL = 1040
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic        req_write,
  input  logic [21:0] req_addr,
  input  logic [31:0] req_wdata,
  output logic        rd_valid,
  output logic [31:0] rd_data,
  output logic        init_done,
  output logic        sd_cs_n,
  output logic        sd_ras_n,
  output logic        sd_cas_n,
  output logic        sd_we_n,
  output logic [1:0]  sd_ba,
  output logic [11:0] sd_addr,
  output logic [1:0]  sd_dqm,
  output logic [15:0] sd_dq_out,
  output logic        sd_dq_oe,
  input  logic [15:0] sd_dq_in
);
  sd_cmd_e          i_cmd, m_cmd, cmd;
  logic [ROW_W-1:0] i_addr, m_addr;
  logic [BANK_W-1:0] m_ba;
  logic             ref_pending, ref_ack;

  sdc_init_seq #(
    .INIT_WAIT(INIT_WAIT), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .INIT_REFS(INIT_REFS)
  ) u_init (
    .clk(clk), .rst_n(rst_n), .cmd(i_cmd), .addr(i_addr), .done(init_done)
  );

  sdc_refresh_tmr #(.REF_INTERVAL(REF_INTERVAL)) u_ref (
    .clk(clk), .rst_n(rst_n), .en(init_done), .ack(ref_ack), .pending(ref_pending)
  );

  sdc_access_fsm #(.T_RCD(T_RCD), .T_RFC(T_RFC), .T_RP(T_RP), .T_WR(T_WR)) u_fsm (
    .clk(clk), .rst_n(rst_n), .init_done(init_done),
    .ref_pending(ref_pending), .ref_ack(ref_ack),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data),
    .cmd(m_cmd), .ba(m_ba), .addr(m_addr),
    .dq_out(sd_dq_out), .dq_oe(sd_dq_oe), .dq_in(sd_dq_in)
  );

  assign cmd     = init_done ? m_cmd  : i_cmd;
  assign sd_addr = init_done ? m_addr : i_addr;
  assign sd_ba   = init_done ? m_ba   : '0;
  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign sd_dqm  = 2'b00;

  AST_NO_READY_IN_INIT: assert property (@(posedge clk) disable iff (!rst_n)
    !init_done |-> !req_ready); // R2
  AST_A10_ON_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD || cmd == CMD_WR) |-> sd_addr[10]); // R3
endmodule

// File: tb/sdram_single_ctrl_bench.sv
module sdram_single_ctrl_bench;
  localparam int CLK_PERIOD = 10;
  localparam int INIT_WAIT = 40, INIT_REFS = 2, T_RP = 3, T_RFC = 7;
  localparam int T_MRD = 2, T_RCD = 3, T_WR = 2, REF_INTERVAL = 300, CL = 3;
  localparam int REF_SLACK = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic req_ready, rd_valid, init_done;
  logic [31:0] rd_data;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba, sd_dqm;
  logic [11:0] sd_addr;
  logic [15:0] sd_dq_out;
  logic [15:0] sd_dq_in = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdram_single_ctrl #(
    .INIT_WAIT(INIT_WAIT), .INIT_REFS(INIT_REFS), .T_RP(T_RP), .T_RFC(T_RFC),
    .T_MRD(T_MRD), .T_RCD(T_RCD), .T_WR(T_WR), .REF_INTERVAL(REF_INTERVAL)
  ) u_sdram_single_ctrl (.*);

  int errors = 0, checks = 0;
  int cyc = 0;
  bit finished = 1'b0;

  task automatic chk(bit ok, string req, string what, longint act, longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  // memory model and pin monitor, all at negedge
  logic [15:0] mem [int];
  logic [11:0] open_row [4];
  int  wr_hi_key = -1, rd_key = 0, rd_cyc = -100, act_cyc = -100;
  int  last_ref = -1, last_cmd_cyc = -100, ref_cnt = 0, act_cnt = 0, hs_cnt = 0;
  int  init_step = 0, init_last = 0, first_ready = -1, mode_cyc = 0;
  int  pre_noise = 0, oe_stray = 0, busy_stray = 0, rfc_viol = 0;
  bit  wr_hi_due = 0, busy_expect = 0;
  logic [21:0] cur_addr;
  logic [31:0] cur_data;

  always @(negedge clk) if (rst_n) begin
    logic [3:0] c;
    c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
    if (sd_dqm != 2'b00) chk(0, "R5", "dqm", sd_dqm, 0);
    if (req_ready && first_ready < 0) begin
      first_ready = cyc;
      chk(first_ready == mode_cyc + T_MRD && init_step == INIT_REFS + 2, "R2",
          "first ready cycle", first_ready, mode_cyc + T_MRD);
    end
    if (busy_expect && req_ready) busy_stray++;
    if (sd_dq_oe && !(c == 4'b0100 || wr_hi_due)) oe_stray++;
    if (wr_hi_due) begin
      chk(sd_dq_oe && sd_dq_out == cur_data[31:16], "R5", "second write word",
          sd_dq_out, cur_data[31:16]);
      mem[wr_hi_key] = sd_dq_out;
      wr_hi_due = 0;
    end
    if (cyc == rd_cyc + 3) sd_dq_in = mem[rd_key];
    if (cyc == rd_cyc + 4) sd_dq_in = mem[rd_key ^ 1];
    if (init_step <= INIT_REFS + 1) begin
      // power-up phase
      if (init_step == 0) begin
        if (c == 4'b0010) begin
          chk(cyc == INIT_WAIT && sd_addr[10], "R1", "precharge-all cycle", cyc, INIT_WAIT);
          chk(pre_noise == 0, "R1", "commands before precharge", pre_noise, 0);
          init_step = 1; init_last = cyc;
        end else if (c != 4'b0111 || req_ready) pre_noise++;
      end else if (c != 4'b0111) begin
        if (init_step <= INIT_REFS) begin
          chk(c == 4'b0001 && cyc == init_last + (init_step == 1 ? T_RP : T_RFC),
              "R2", "init refresh slot", cyc, init_last + (init_step == 1 ? T_RP : T_RFC));
        end else begin
          chk(c == 4'b0000 && sd_addr == 12'h031 && cyc == init_last + T_RFC,
              "R2", "mode command", {c, sd_addr}, {4'b0000, 12'h031});
          mode_cyc = cyc; last_ref = cyc + T_MRD;
        end
        init_step++; init_last = cyc;
      end
    end else if (c != 4'b0111) begin
      if (cyc - last_cmd_cyc < T_RFC && last_cmd_cyc == last_ref) rfc_viol++;
      case (c)
        4'b0001: begin
          ref_cnt++;
          chk(cyc - last_ref <= REF_INTERVAL + REF_SLACK, "R8", "refresh gap",
              cyc - last_ref, REF_INTERVAL + REF_SLACK);
          last_ref = cyc;
        end
        4'b0011: begin
          act_cnt++; act_cyc = cyc;
          open_row[sd_ba] = sd_addr;
          chk({sd_ba, sd_addr} == cur_addr[21:8], "R3", "active bank/row",
              {sd_ba, sd_addr}, cur_addr[21:8]);
        end
        4'b0100, 4'b0101: begin
          chk(cyc - act_cyc == T_RCD, "R4", "activate-to-column gap", cyc - act_cyc, T_RCD);
          chk({sd_ba, sd_addr} == {cur_addr[21:20], 4'b0100, cur_addr[7:0]}, "R3",
              "column command address", {sd_ba, sd_addr},
              {cur_addr[21:20], 4'b0100, cur_addr[7:0]});
          if (c == 4'b0100) begin
            chk(sd_dq_oe && sd_dq_out == cur_data[15:0], "R5", "first write word",
                sd_dq_out, cur_data[15:0]);
            mem[{sd_ba, open_row[sd_ba], sd_addr[7:0]}] = sd_dq_out;
            wr_hi_key = {sd_ba, open_row[sd_ba], sd_addr[7:0]} ^ 1;
            wr_hi_due = 1;
          end else begin
            rd_key = {sd_ba, open_row[sd_ba], sd_addr[7:0]};
            rd_cyc = cyc;
          end
        end
        default: chk(0, "R1", "unexpected command", c, 4'b0111);
      endcase
      last_cmd_cyc = cyc;
    end
  end

  function automatic logic [31:0] pat(logic [21:0] a);
    return (32'(a) * 32'h9E37_79B1) ^ 32'hA5A5_0F0F;
  endfunction

  task automatic access(bit wr, logic [21:0] a, logic [31:0] d, output logic [31:0] q);
    @(negedge clk);
    cur_addr = a; cur_data = d;
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    hs_cnt++;
    @(negedge clk);
    req_valid = 1'b0;
    busy_expect = 1;
    q = '0;
    if (wr) begin
      while (!wr_hi_due) @(negedge clk);
      @(negedge clk);
    end else begin
      while (!rd_valid) @(negedge clk);
      chk(cyc == rd_cyc + CL + 2, "R6", "read strobe cycle", cyc, rd_cyc + CL + 2);
      q = rd_data;
      @(negedge clk);
      chk(!rd_valid, "R6", "strobe is one cycle", rd_valid, 0);
    end
    busy_expect = 0;
  endtask

  function automatic logic [21:0] sweep_addr(int i);
    logic [11:0] rows [3];
    logic [7:0]  cols [3];
    rows = '{12'h000, 12'hFFF, 12'h5A3};
    cols = '{8'h00, 8'h02, 8'hFE};
    return {2'(i / 9), rows[(i / 3) % 3], cols[i % 3]};
  endfunction

  initial begin
    logic [31:0] q;
    chk(!req_ready && !init_done && !rd_valid && !sd_dq_oe, "R1", "reset outputs",
        {req_ready, init_done, rd_valid, sd_dq_oe}, 0);
    repeat (4) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    rst_n = 1'b1;
    for (int i = 0; i < 36; i++) access(1'b1, sweep_addr(i), pat(sweep_addr(i)), q);
    for (int i = 0; i < 36; i++) begin
      access(1'b0, sweep_addr(i), 32'h0, q);
      chk(q == pat(sweep_addr(i)), "R10", "read-back", q, pat(sweep_addr(i)));
    end
    // odd start column: burst wraps within the pair
    access(1'b1, 22'h2A_BCFF, 32'h1234_ABCD, q);
    access(1'b0, 22'h2A_BCFE, 32'h0, q);
    chk(q == 32'hABCD_1234, "R6", "wrapped burst order", q, 32'hABCD_1234);
    repeat (2 * REF_INTERVAL + 10) @(negedge clk);
    chk(ref_cnt >= 2, "R8", "refreshes seen", ref_cnt, 2);
    chk(act_cnt == hs_cnt, "R7", "one ACTIVE per request", act_cnt, hs_cnt);
    chk(busy_stray == 0, "R7", "ready during access", busy_stray, 0);
    chk(oe_stray == 0, "R5", "stray data enable", oe_stray, 0);
    chk(rfc_viol == 0, "R9", "command inside refresh window", rfc_viol, 0);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule